// File: doc/BRIEF.md
# Sampling Phase Tuning Controller

This block picks the receive sampling delay for a high-speed SD or eMMC host. A one-cycle start pulse makes it step a 7-bit delay code upward from zero in steps of four. For each code it first asks an external delay-programming block to apply the code. It then asks a tuning-command engine to run one tuning-block transfer and report pass or fail. While doing this it follows runs of neighbouring passing codes and keeps the longest one.

After the last code it checks the result. If a window was found and the tuned sampling clock reports itself selected, the controller applies a code three quarters of the way into the best window. If not, it drops back to the fixed sampling clock and reports an error. In both cases it then resets the data path and the command path, in that order, and raises a one-cycle done pulse. Slow bus clocks, and the SDR50 mode on hosts that do not need SDR50 tuning, skip the sweep and report success at once.

Top module: `phase_tune_ctrl`

## Requirements
- R1: During and after reset, all request, reset, done, enable and status outputs are low and `final_code` is 0.
- R2: When `op_clk_khz` is at most 52000, a start pulse gives a done pulse with `err` low, with no delay or trial request and no path reset. `final_code` keeps its previous value.
- R3: When `bus_mode` is 3'd2 (SDR50) and `sdr50_tune_cap` is low, a start is skipped as in R2. With `sdr50_tune_cap` high, the sweep runs.
- R4: A sweep applies the codes 0, 4, 8, … 0x7C in this order, exactly 32 of them. Each one is programmed through a `dly_req`/`dly_ack` handshake before its trial, and `dly_req` and `trial_req` are never high together.
- R5: A pass after a fail or at sweep start opens a run at the current code with length 1, and a pass after a pass lengthens the run. The best window is replaced only by a strictly longer run, so the earliest of equal windows is kept.
- R6: On success the controller programs the code best_start + 4·((3·best_length)>>2) through one more delay handshake and reports it on `final_code` with `err` low.
- R7: If no trial passes, `err` goes high, `final_code` becomes 0, and `sweep_en` and `force_en` are low at done.
- R8: If `clk_sel_ok` is low when the sweep ends, the result is an error as in R7, even when a window exists.
- R9: While `tune_active` is high (the whole sweep), both bits of `dat_irq_en_o` are 0 (bit 0 data-CRC, bit 1 data end-bit). Otherwise they follow `dat_irq_en_i`.
- R10: After a sweep, on success or error, `dpath_rst` pulses for one cycle, then `cpath_rst` pulses in the next cycle, then `done`.
- R11: `done` lasts one cycle, and `err` and `final_code` stay unchanged from done until the next start.
- R12: `trial_req` stays high until `trial_done`, and the controller waits however long the response takes. `trial_pass` is sampled only in the cycle `trial_done` is high.
- R13: `sweep_en` and `force_en` rise when a sweep starts, stay high through the sweep, and stay high after success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to tune |
| op_clk_khz | input | 20 | Current bus clock in kHz |
| bus_mode | input | 3 | Bus timing mode; 3'd2 is SDR50 |
| sdr50_tune_cap | input | 1 | Host needs tuning in SDR50 |
| clk_sel_ok | input | 1 | Tuned sampling clock is selected |
| dly_req | output | 1 | Request to apply `dly_code` |
| dly_code | output | 7 | Delay code to apply |
| dly_ack | input | 1 | Delay applied (one cycle) |
| trial_req | output | 1 | Request one tuning-block transfer |
| trial_done | input | 1 | Trial response valid (one cycle) |
| trial_pass | input | 1 | Trial result, valid with `trial_done` |
| dat_irq_en_i | input | 2 | Data error interrupt enables in |
| dat_irq_en_o | output | 2 | Enables after masking during the sweep |
| tune_active | output | 1 | Sweep in progress |
| sweep_en | output | 1 | Software-tuning enable to the delay block |
| force_en | output | 1 | Forced-delay enable to the delay block |
| dpath_rst | output | 1 | Data-path reset pulse |
| cpath_rst | output | 1 | Command-path reset pulse |
| done | output | 1 | Tuning finished (one cycle) |
| err | output | 1 | Result status: 1 means tuning failed |
| final_code | output | 7 | Delay code chosen by the last tuning |

## Verification
The assertions assume that the responders follow the handshake. `dly_ack` and `trial_done` come only while the matching request is high, are one cycle long, and arrive in some later cycle, never all at once with the next request. The bench's responders act only at the falling edge. They raise the acknowledge after a chosen latency of zero to two cycles while the request is seen, and drop it again at the next falling edge. `start` is pulsed only while the controller is idle. `clk_sel_ok` is held constant for a whole run.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET,
    ST_TRIAL,
    ST_JUDGE,
    ST_FINAL,
    ST_RSTD,
    ST_RSTC,
    ST_DONE
  } tune_state_e;

  localparam logic [2:0] MODE_SDR12  = 3'd0;
  localparam logic [2:0] MODE_SDR25  = 3'd1;
  localparam logic [2:0] MODE_SDR50  = 3'd2;
  localparam logic [2:0] MODE_SDR104 = 3'd3;
  localparam logic [2:0] MODE_DDR50  = 3'd4;

endpackage

// File: rtl/phase_tune_window.sv
module phase_tune_window #(
  parameter int CODE_W     = 7,
  parameter int STEP_LOG2  = 2,
  parameter int NUM_TRIALS = 32,
  parameter int LEN_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic              pass,
  input  logic [CODE_W-1:0] code,
  output logic              no_window,
  output logic [CODE_W-1:0] cand_code
);
  localparam int CALC_W = CODE_W + LEN_W + STEP_LOG2;

  logic              prev_q, prev_d;
  logic [CODE_W-1:0] run_start_q, run_start_d;
  logic [LEN_W-1:0]  run_len_q, run_len_d;
  logic [CODE_W-1:0] best_start_q, best_start_d;
  logic [LEN_W-1:0]  best_len_q, best_len_d;
  logic              reg_en;

  assign reg_en = clr | upd;

  // run and best-window update
  always_comb begin
    prev_d       = prev_q;
    run_start_d  = run_start_q;
    run_len_d    = run_len_q;
    best_start_d = best_start_q;
    best_len_d   = best_len_q;
    if (clr) begin
      prev_d       = 1'b0;
      run_start_d  = '0;
      run_len_d    = '0;
      best_start_d = '0;
      best_len_d   = '0;
    end else if (upd) begin
      if (pass) begin
        if (prev_q) begin
          run_len_d = run_len_q + LEN_W'(1);
        end else begin
          run_start_d = code;
          run_len_d   = LEN_W'(1);
        end
      end
      prev_d = pass;
      if (run_len_d > best_len_q) begin
        best_start_d = run_start_d;
        best_len_d   = run_len_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q       <= 1'b0;
      run_start_q  <= '0;
      run_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (reg_en) begin
      prev_q       <= prev_d;
      run_start_q  <= run_start_d;
      run_len_q    <= run_len_d;
      best_start_q <= best_start_d;
      best_len_q   <= best_len_d;
    end
  end

  // three-quarter point of the best window
  logic [LEN_W+1:0]  len3;
  logic [LEN_W-1:0]  quarter;
  logic [CALC_W-1:0] cand_wide;

  assign len3      = {2'b00, best_len_q} + {1'b0, best_len_q, 1'b0};
  assign quarter   = len3[LEN_W+1:2];
  assign cand_wide = CALC_W'(best_start_q) + (CALC_W'(quarter) << STEP_LOG2);
  assign cand_code = cand_wide[CODE_W-1:0];
  assign no_window = (best_len_q == '0);

  // R5: the best length never shrinks within a sweep
  a_r5_best_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> best_len_q >= $past(best_len_q));

  // R5: a run can be no longer than the number of trials
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    best_len_q <= LEN_W'(NUM_TRIALS));

endmodule

// File: rtl/phase_tune_fsm.sv
module phase_tune_fsm
  import phase_tune_pkg::*;
#(
  parameter int CODE_W    = 7,
  parameter int STEP_LOG2 = 2,
  parameter int CODE_MAX  = 124
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              skip,
  input  logic              clk_sel_ok,
  input  logic              dly_ack,
  input  logic              trial_done,
  input  logic              no_window,
  input  logic [CODE_W-1:0] cand_code,
  output logic              dly_req,
  output logic [CODE_W-1:0] dly_code,
  output logic              trial_req,
  output logic [CODE_W-1:0] trk_code,
  output logic              trk_clr,
  output logic              trk_upd,
  output logic              tune_active,
  output logic              sweep_en,
  output logic              force_en,
  output logic              dpath_rst,
  output logic              cpath_rst,
  output logic              done,
  output logic              err,
  output logic [CODE_W-1:0] final_code
);
  localparam logic [CODE_W-1:0] STEP_C = CODE_W'(1 << STEP_LOG2);
  localparam logic [CODE_W-1:0] LAST_C = CODE_W'(CODE_MAX);

  tune_state_e       state_q, state_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] fin_q, fin_d;
  logic              err_q, err_d;
  logic              swp_q, swp_d;
  logic              frc_q, frc_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    fin_d   = fin_q;
    err_d   = err_q;
    swp_d   = swp_q;
    frc_d   = frc_q;
    trk_clr = 1'b0;
    trk_upd = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          err_d = 1'b0;
          if (skip) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_SET;
            code_d  = '0;
            swp_d   = 1'b1;
            frc_d   = 1'b1;
            trk_clr = 1'b1;
          end
        end
      end
      ST_SET: begin
        if (dly_ack) state_d = ST_TRIAL;
      end
      ST_TRIAL: begin
        if (trial_done) begin
          trk_upd = 1'b1;
          if (code_q == LAST_C) begin
            state_d = ST_JUDGE;
          end else begin
            code_d  = code_q + STEP_C;
            state_d = ST_SET;
          end
        end
      end
      ST_JUDGE: begin
        if (no_window || !clk_sel_ok) begin
          err_d   = 1'b1;
          fin_d   = '0;
          swp_d   = 1'b0;
          frc_d   = 1'b0;
          state_d = ST_RSTD;
        end else begin
          fin_d   = cand_code;
          state_d = ST_FINAL;
        end
      end
      ST_FINAL: begin
        if (dly_ack) state_d = ST_RSTD;
      end
      ST_RSTD: state_d = ST_RSTC;
      ST_RSTC: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      fin_q   <= '0;
      err_q   <= 1'b0;
      swp_q   <= 1'b0;
      frc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      fin_q   <= fin_d;
      err_q   <= err_d;
      swp_q   <= swp_d;
      frc_q   <= frc_d;
    end
  end

  assign dly_req     = (state_q == ST_SET) || (state_q == ST_FINAL);
  assign dly_code    = (state_q == ST_FINAL) ? fin_q : code_q;
  assign trial_req   = (state_q == ST_TRIAL);
  assign trk_code    = code_q;
  assign tune_active = (state_q == ST_SET) || (state_q == ST_TRIAL);
  assign dpath_rst   = (state_q == ST_RSTD);
  assign cpath_rst   = (state_q == ST_RSTC);
  assign done        = (state_q == ST_DONE);
  assign err         = err_q;
  assign final_code  = fin_q;
  assign sweep_en    = swp_q;
  assign force_en    = frc_q;

  // R4: a delay request holds its code until acknowledged
  a_r4_dly_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dly_req && !dly_ack |=> dly_req && $stable(dly_code));

  // R4: delay and trial requests never overlap
  a_r4_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_req && trial_req));

  // R12: a trial request waits for its response
  a_r12_trial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req && !trial_done |=> trial_req);

  // R10: command-path reset directly follows data-path reset
  a_r10_rst_order: assert property (@(posedge clk) disable iff (!rst_n)
    dpath_rst |=> cpath_rst);

  // R10: done directly follows the command-path reset
  a_r10_done_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
    cpath_rst |=> done);

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: result held while idle
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) && !start |=> $stable(final_code) && $stable(err));

  // R7: an error result leaves both enables cleared
  a_r7_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> !sweep_en && !force_en);

endmodule

// File: rtl/phase_tune_ctrl.sv
module phase_tune_ctrl
  import phase_tune_pkg::*;
#(
  parameter int CODE_W    = 7,
  parameter int STEP_LOG2 = 2,
  parameter int CODE_MAX  = 124,
  parameter int CLK_W     = 20,
  parameter int SLOW_KHZ  = 52000,
  parameter int IRQ_N     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CLK_W-1:0]  op_clk_khz,
  input  logic [2:0]        bus_mode,
  input  logic              sdr50_tune_cap,
  input  logic              clk_sel_ok,
  output logic              dly_req,
  output logic [CODE_W-1:0] dly_code,
  input  logic              dly_ack,
  output logic              trial_req,
  input  logic              trial_done,
  input  logic              trial_pass,
  input  logic [IRQ_N-1:0]  dat_irq_en_i,
  output logic [IRQ_N-1:0]  dat_irq_en_o,
  output logic              tune_active,
  output logic              sweep_en,
  output logic              force_en,
  output logic              dpath_rst,
  output logic              cpath_rst,
  output logic              done,
  output logic              err,
  output logic [CODE_W-1:0] final_code
);
  localparam int NUM_TRIALS = (CODE_MAX >> STEP_LOG2) + 1;
  localparam int LEN_W      = $clog2(NUM_TRIALS + 1);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // skip decision
  logic skip_slow, skip_sdr50, skip;
  assign skip_slow  = (op_clk_khz <= CLK_W'(SLOW_KHZ));
  assign skip_sdr50 = (bus_mode == MODE_SDR50) && !sdr50_tune_cap;
  assign skip       = skip_slow || skip_sdr50;

  logic              trk_clr, trk_upd, no_window;
  logic [CODE_W-1:0] trk_code, cand_code;

  phase_tune_fsm #(
    .CODE_W   (CODE_W),
    .STEP_LOG2(STEP_LOG2),
    .CODE_MAX (CODE_MAX)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .skip       (skip),
    .clk_sel_ok (clk_sel_ok),
    .dly_ack    (dly_ack),
    .trial_done (trial_done),
    .no_window  (no_window),
    .cand_code  (cand_code),
    .dly_req    (dly_req),
    .dly_code   (dly_code),
    .trial_req  (trial_req),
    .trk_code   (trk_code),
    .trk_clr    (trk_clr),
    .trk_upd    (trk_upd),
    .tune_active(tune_active),
    .sweep_en   (sweep_en),
    .force_en   (force_en),
    .dpath_rst  (dpath_rst),
    .cpath_rst  (cpath_rst),
    .done       (done),
    .err        (err),
    .final_code (final_code)
  );

  phase_tune_window #(
    .CODE_W    (CODE_W),
    .STEP_LOG2 (STEP_LOG2),
    .NUM_TRIALS(NUM_TRIALS),
    .LEN_W     (LEN_W)
  ) win_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (trk_clr),
    .upd      (trk_upd),
    .pass     (trial_pass),
    .code     (trk_code),
    .no_window(no_window),
    .cand_code(cand_code)
  );

  // per-bit interrupt masking while sweeping
  for (genvar g = 0; g < IRQ_N; g++) begin : g_irq_mask
    assign dat_irq_en_o[g] = dat_irq_en_i[g] & ~tune_active;
  end

  // R9: no data error interrupt can be enabled while a trial runs
  a_r9_mask_in_trial: assert property (@(posedge clk) disable iff (!rst_core_n)
    trial_req |-> dat_irq_en_o == '0);

  // R2: a skipped start never programs a delay in the next cycle
  a_r2_skip_no_dly: assert property (@(posedge clk) disable iff (!rst_core_n)
    start && skip && !dly_req && !trial_req && !done && !dpath_rst && !cpath_rst
      && !$past(start) |=> !dly_req);

endmodule

// File: tb/phase_tune_ctrl_tb_top.sv
`timescale 1ns/1ps
module phase_tune_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [19:0] op_clk_khz;
  logic [2:0]  bus_mode;
  logic        sdr50_tune_cap;
  logic        clk_sel_ok;
  logic        dly_req;
  logic [6:0]  dly_code;
  logic        dly_ack;
  logic        trial_req;
  logic        trial_done;
  logic        trial_pass;
  logic [1:0]  dat_irq_en_i;
  logic [1:0]  dat_irq_en_o;
  logic        tune_active;
  logic        sweep_en;
  logic        force_en;
  logic        dpath_rst;
  logic        cpath_rst;
  logic        done;
  logic        err;
  logic [6:0]  final_code;

  int checks;
  int errors;

  phase_tune_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_clk_khz(op_clk_khz),
    .bus_mode(bus_mode), .sdr50_tune_cap(sdr50_tune_cap), .clk_sel_ok(clk_sel_ok),
    .dly_req(dly_req), .dly_code(dly_code), .dly_ack(dly_ack),
    .trial_req(trial_req), .trial_done(trial_done), .trial_pass(trial_pass),
    .dat_irq_en_i(dat_irq_en_i), .dat_irq_en_o(dat_irq_en_o),
    .tune_active(tune_active), .sweep_en(sweep_en), .force_en(force_en),
    .dpath_rst(dpath_rst), .cpath_rst(cpath_rst), .done(done), .err(err),
    .final_code(final_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // longest run of ones, earliest on a tie, as (start code, length)
  task automatic model(input logic [31:0] mask, output int bstart, output int blen);
    int rs, rl;
    bit prev;
    rs = 0; rl = 0; prev = 0; bstart = 0; blen = 0;
    for (int i = 0; i < 32; i++) begin
      if (mask[i]) begin
        if (prev) rl++;
        else begin rs = 4 * i; rl = 1; end
      end
      prev = mask[i];
      if (rl > blen) begin bstart = rs; blen = rl; end
    end
  endtask

  task automatic run_one(input logic [31:0] mask, input logic sel_ok, input int lat,
                         input bit exp_skip);
    int ncodes, cyc, wcnt, rd_cyc, rc_cyc, bstart, blen, exp_final, last_code;
    int prev_final;
    bit both, irq_bad, en_bad, got_done;
    logic [6:0] codes [0:40];
    logic       exp_err;
    ncodes = 0; cyc = 0; wcnt = 0; rd_cyc = -1; rc_cyc = -1; last_code = 0;
    both = 0; irq_bad = 0; en_bad = 0; got_done = 0;
    prev_final = int'(final_code);
    for (int i = 0; i < 41; i++) codes[i] = '0;
    clk_sel_ok = sel_ok;
    model(mask, bstart, blen);
    exp_final = bstart + 4 * ((3 * blen) >> 2);
    exp_err = (blen == 0) || !sel_ok;

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (cyc < 3000) begin
      if (done) begin got_done = 1; break; end
      if (dly_req && trial_req) both = 1;
      if (tune_active && dat_irq_en_o != 2'b00) irq_bad = 1;
      if (!tune_active && dat_irq_en_o != dat_irq_en_i) irq_bad = 1;
      if (dpath_rst) rd_cyc = cyc;
      if (cpath_rst) rc_cyc = cyc;
      if (dly_req) begin
        if (wcnt >= lat) begin
          dly_ack = 1'b1;
          if (ncodes < 32 && !(sweep_en && force_en)) en_bad = 1;
          if (ncodes < 41) begin codes[ncodes] = dly_code; ncodes++; end
          last_code = int'(dly_code);
          wcnt = 0;
        end else wcnt++;
      end else if (trial_req) begin
        if (wcnt >= lat) begin
          trial_done = 1'b1;
          trial_pass = mask[last_code >> 2];
          wcnt = 0;
        end else wcnt++;
      end
      @(negedge clk);
      dly_ack = 1'b0; trial_done = 1'b0; trial_pass = 1'b0;
      cyc++;
    end

    chk(got_done, "R12 done reached", int'(got_done), 1);
    if (exp_skip) begin
      chk(ncodes == 0, "R2/R3 skip issues no delay request", ncodes, 0);
      chk(rd_cyc < 0 && rc_cyc < 0, "R2/R3 skip issues no path reset", rd_cyc, -1);
      chk(err == 1'b0, "R2/R3 skip reports success", int'(err), 0);
      chk(int'(final_code) == prev_final, "R2 skip keeps final code", int'(final_code), prev_final);
    end else begin
      chk(!both, "R4 requests exclusive", int'(both), 0);
      chk(!irq_bad, "R9 interrupt mask follows sweep", int'(irq_bad), 0);
      chk(!en_bad, "R13 enables high during sweep", int'(en_bad), 0);
      chk(ncodes == (exp_err ? 32 : 33), "R4 number of delay applications", ncodes,
          exp_err ? 32 : 33);
      for (int i = 0; i < 32; i++)
        if (codes[i] != 7'(4 * i))
          chk(0, "R4 sweep order", int'(codes[i]), 4 * i);
      chk(err == exp_err, "R5/R7/R8 status", int'(err), int'(exp_err));
      if (exp_err) begin
        chk(final_code == 7'd0, "R7 final code cleared", int'(final_code), 0);
        chk(!sweep_en && !force_en, "R7 enables cleared", int'({sweep_en, force_en}), 0);
      end else begin
        chk(int'(final_code) == exp_final, "R5/R6 final code", int'(final_code), exp_final);
        chk(int'(codes[32]) == exp_final, "R6 final code applied", int'(codes[32]), exp_final);
        chk(sweep_en && force_en, "R13 enables kept on success", int'({sweep_en, force_en}), 3);
      end
      chk(rd_cyc > 0 && rc_cyc == rd_cyc + 1 && cyc == rc_cyc + 1,
          "R10 reset order", rc_cyc - rd_cyc, 1);
    end
    begin
      logic [6:0] f0;
      logic       e0;
      f0 = final_code; e0 = err;
      @(negedge clk);
      chk(!done, "R11 done one cycle", int'(done), 0);
      repeat (4) @(negedge clk);
      chk(final_code == f0 && err == e0, "R11 result stable", int'(final_code), int'(f0));
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    checks = 0; errors = 0;
    rst_n = 1'b0; start = 1'b0; op_clk_khz = 20'd200000; bus_mode = 3'd3;
    sdr50_tune_cap = 1'b0; clk_sel_ok = 1'b1; dly_ack = 1'b0; trial_done = 1'b0;
    trial_pass = 1'b0; dat_irq_en_i = 2'b11;
    repeat (3) @(negedge clk);
    chk({dly_req, trial_req, done, err, sweep_en, force_en, dpath_rst, cpath_rst, tune_active} == 9'd0
        && final_code == 7'd0, "R1 reset state", int'(final_code), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({dly_req, trial_req, done, err} == 4'd0, "R1 idle after reset", int'(dly_req), 0);

    // directed windows
    run_one(32'hFFFF_FFFF, 1'b1, 0, 0);
    run_one(32'h0000_0000, 1'b1, 1, 0);
    run_one(32'h0000_0001, 1'b1, 2, 0);
    run_one(32'h8000_0000, 1'b1, 0, 0);
    run_one(32'h0F00_00F0, 1'b1, 1, 0);   // tie: earlier window kept
    run_one(32'h0FF0_00F0, 1'b1, 2, 0);
    run_one(32'h5555_5555, 1'b1, 0, 0);
    run_one(32'h00FF_FF00, 1'b0, 1, 0);   // R8
    // R2 boundary
    op_clk_khz = 20'd52000;
    run_one(32'hFFFF_FFFF, 1'b1, 0, 1);
    op_clk_khz = 20'd52001;
    run_one(32'h0000_FFFF, 1'b1, 1, 0);
    // R3
    op_clk_khz = 20'd100000; bus_mode = 3'd2; sdr50_tune_cap = 1'b0;
    run_one(32'hFFFF_FFFF, 1'b1, 0, 1);
    sdr50_tune_cap = 1'b1;
    run_one(32'h0003_FF00, 1'b1, 2, 0);
    bus_mode = 3'd3;
    dat_irq_en_i = 2'b01;
    run_one(32'h3C00_0000, 1'b1, 0, 0);
    dat_irq_en_i = 2'b11;
    // pseudo-random masks, including sparse ones
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 36; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_one((k % 3 == 0) ? (lfsr & (lfsr >> 3)) : lfsr, (k % 7) != 6, k % 3, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule